// File: doc/BRIEF.md
# FPGA Slave-SPI Configuration Sequencer

This block sits on the host side of a board and loads a configuration image into a target FPGA through the target's slave-SPI port. A start request first triggers a timed reset of the target, with chip select held low. The block then confirms that the target has cleared its configuration-complete ("done") line and waits out the target's housekeeping interval. Chip select is released briefly and then asserted again while the image is streamed in. Image bytes arrive on a valid/ready byte stream that has a last-byte flag. Each byte is shifted out most significant bit first, using SPI mode 0 with a divided clock.

After the final image byte, the block expects the done line to be high. It then sends zero-filled activation bytes, pulses a success strobe and returns to idle. While it idles after a good load, it mirrors the done line as an "operating" indication. Any failure ends the sequence and leaves a 2-bit error code that stays in place until the next start request. A request marked as partial reconfiguration is refused at once.

States: `ST_IDLE`, `ST_RST_HOLD` (target reset and chip select low), `ST_RST_CHECK` (done must be low), `ST_HOUSEKEEP` (timed wait, chip select low), `ST_CS_GAP` (chip select high), `ST_STREAM` (await byte), `ST_SHIFT` (byte on the wire), `ST_LOAD_CHECK` (done must be high), `ST_PAD` / `ST_PAD_SHIFT` (zero bytes), `ST_FINISH` (success strobe). Transitions:
- IDLE→RST_HOLD on a full start.
- RST_HOLD→RST_CHECK when the reset timer expires.
- RST_CHECK→IDLE if done is high, otherwise RST_CHECK→HOUSEKEEP.
- HOUSEKEEP→CS_GAP when the housekeeping timer expires, then CS_GAP→STREAM.
- STREAM→SHIFT when a byte is accepted.
- SHIFT→STREAM after a byte that is not the last, or SHIFT→LOAD_CHECK after the last byte.
- LOAD_CHECK→IDLE if done is low, otherwise LOAD_CHECK→PAD.
- PAD→PAD_SHIFT for each zero byte, PAD_SHIFT→PAD until the final one, then PAD_SHIFT→FINISH→IDLE.

Top module: `fpga_spi_loader`

## Requirements
- R1: After reset: tgt_rst_n_o=1, spi_cs_n_o=1, spi_sclk_o=0, busy_o=0, done_ok_o=0, s_ready_o=0, err_o=0.
- R2: A start with partial_i=0 drives tgt_rst_n_o and spi_cs_n_o low together. The target reset then stays low for at least ceil(CLK_HZ*RESET_US/1e6) cycles, and it is never low while chip select is high.
- R3: If the synchronised done input is high just after the target reset is released, the block goes idle with err_o=1 (reset failure). No SCLK edges are produced.
- R4: After the reset is released, chip select stays low for at least ceil(CLK_HZ*HK_US/1e6) cycles. It then goes high for at least one cycle before the first SCLK edge. No SCLK edge occurs before that point.
- R5: SCLK is low whenever chip select is high. Its period is 2*HALF_DIV cycles. MOSI never changes in a cycle in which SCLK rises (mode 0).
- R6: s_ready_o is high only while the block awaits an image byte. Each accepted byte appears on MOSI most significant bit first, in order, and gaps in s_valid_i are tolerated.
- R7: If done is low once the byte flagged last has been shifted, the block goes idle with err_o=2 (load failure) and sends no padding.
- R8: If done is high at that point, PAD_BYTES zero bytes (8*PAD_BYTES SCLK rises, MOSI=0) follow with chip select held low. A one-cycle done_ok_o pulse and then idle follow.
- R9: A start with partial_i=1 sets err_o=3 (unsupported). The target reset is not asserted and busy_o stays 0.
- R10: err_o keeps its value in idle until the next start request, which clears it (or sets 3 for a partial request).
- R11: operating_o follows the done input (two-cycle synchroniser) while idle after a successful load, and is 0 once done drops.
- R12: A start request while busy_o=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request pulse |
| partial_i | input | 1 | Request is a partial reconfiguration |
| s_data_i | input | 8 | Image byte |
| s_valid_i | input | 1 | Image byte valid |
| s_last_i | input | 1 | Image byte is the last one |
| s_ready_o | output | 1 | Block accepts an image byte |
| done_in_i | input | 1 | Target configuration-complete line |
| tgt_rst_n_o | output | 1 | Active-low target reset |
| spi_cs_n_o | output | 1 | Active-low SPI chip select |
| spi_sclk_o | output | 1 | SPI clock (mode 0) |
| spi_mosi_o | output | 1 | SPI data to target |
| busy_o | output | 1 | Sequence in progress |
| done_ok_o | output | 1 | One-cycle success pulse |
| err_o | output | 2 | 0 none, 1 reset failure, 2 load failure, 3 unsupported |
| operating_o | output | 1 | Target reported operating after a good load |

## Verification
Two functions can coincide: the handling of new start requests and a sequence that is already running on its timers. The bench provokes this with a second start pulse in the middle of the housekeeping wait. It judges the outcome by counting target-reset falling edges (exactly one per run) and by requiring that the streamed bytes and padding still arrive intact. A second coincidence is the arrival of a new byte in the same cycle as the finish of the previous one. The bench provokes it with back-to-back bytes and with a stall in s_valid_i, and a scoreboard compares every byte reassembled from MOSI at SCLK rising edges.

// File: rtl/fpga_loader_pkg.sv
package fpga_loader_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_HOLD,
        ST_RST_CHECK,
        ST_HOUSEKEEP,
        ST_CS_GAP,
        ST_STREAM,
        ST_SHIFT,
        ST_LOAD_CHECK,
        ST_PAD,
        ST_PAD_SHIFT,
        ST_FINISH
    } ld_state_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_RESET = 2'd1,
        ERR_LOAD  = 2'd2,
        ERR_UNSUP = 2'd3
    } ld_err_e;

    // Microseconds to system cycles, rounded up so minimum times are met.
    function automatic longint unsigned us_to_cycles(longint unsigned clk_hz,
                                                     longint unsigned us);
        return (clk_hz * us + 64'd999_999) / 64'd1_000_000;
    endfunction

endpackage

// File: rtl/loader_timer.sv
module loader_timer #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= value;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/loader_shifter.sv
module loader_shifter #(
    parameter int HALF_DIV = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] byte_i,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       fin_o
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic          active;
    logic [7:0]    sreg;
    logic [DW-1:0] div;
    logic [3:0]    edges;
    logic          sclk_q;
    logic          fin_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            sreg   <= '0;
            div    <= '0;
            edges  <= '0;
            sclk_q <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load) begin
                active <= 1'b1;
                sreg   <= byte_i;
                div    <= '0;
                edges  <= '0;
                sclk_q <= 1'b0;
            end else if (active) begin
                if (div == DW'(HALF_DIV - 1)) begin
                    div    <= '0;
                    sclk_q <= ~sclk_q;
                    edges  <= edges + 4'd1;
                    if (sclk_q) begin
                        sreg <= {sreg[6:0], 1'b0};
                    end
                    if (edges == 4'd15) begin
                        active <= 1'b0;
                        fin_q  <= 1'b1;
                    end
                end else begin
                    div <= div + 1'b1;
                end
            end
        end
    end

    assign sclk_o = sclk_q;
    assign mosi_o = active & sreg[7];
    assign fin_o  = fin_q;

    // R5: data is held steady across every rising clock edge
    assert_mosi_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(mosi_o));

    // R5: a byte always ends with the clock back at its idle level
    assert_fin_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |-> !sclk_o);

endmodule

// File: rtl/fpga_spi_loader.sv
module fpga_spi_loader
    import fpga_loader_pkg::*;
#(
    parameter longint unsigned CLK_HZ    = 125_000_000,
    parameter int              RESET_US  = 1,
    parameter int              HK_US     = 1200,
    parameter int              HALF_DIV  = 3,
    parameter int              PAD_BYTES = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       partial_i,
    input  logic [7:0] s_data_i,
    input  logic       s_valid_i,
    input  logic       s_last_i,
    output logic       s_ready_o,
    input  logic       done_in_i,
    output logic       tgt_rst_n_o,
    output logic       spi_cs_n_o,
    output logic       spi_sclk_o,
    output logic       spi_mosi_o,
    output logic       busy_o,
    output logic       done_ok_o,
    output logic [1:0] err_o,
    output logic       operating_o
);
    localparam longint unsigned RST_CYC = us_to_cycles(CLK_HZ, 64'(RESET_US));
    localparam longint unsigned HK_CYC  = us_to_cycles(CLK_HZ, 64'(HK_US));
    localparam longint unsigned MAX_CYC = (HK_CYC > RST_CYC) ? HK_CYC : RST_CYC;
    localparam int TW = $clog2(MAX_CYC + 1);
    localparam int PW = (PAD_BYTES > 1) ? $clog2(PAD_BYTES) : 1;

    ld_state_e     state, state_n;
    ld_err_e       err_q;
    logic          ok_q;
    logic          last_q;
    logic [PW-1:0] pad_cnt;
    logic          done_m, done_s;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          sh_load;
    logic [7:0]    sh_byte;
    logic          sh_fin;

    // two-flop synchroniser for the target done line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_m <= 1'b0;
            done_s <= 1'b0;
        end else begin
            done_m <= done_in_i;
            done_s <= done_m;
        end
    end

    // state register and sequence bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            err_q   <= ERR_NONE;
            ok_q    <= 1'b0;
            last_q  <= 1'b0;
            pad_cnt <= '0;
        end else begin
            state <= state_n;
            if (state == ST_IDLE && start_i) begin
                err_q <= partial_i ? ERR_UNSUP : ERR_NONE;
                ok_q  <= 1'b0;
            end
            if (state == ST_RST_CHECK && done_s) err_q <= ERR_RESET;
            if (state == ST_LOAD_CHECK && !done_s) err_q <= ERR_LOAD;
            if (state == ST_FINISH) ok_q <= 1'b1;
            if (state == ST_STREAM && s_valid_i) last_q <= s_last_i;
            if (state == ST_LOAD_CHECK) pad_cnt <= '0;
            if (state == ST_PAD_SHIFT && sh_fin) pad_cnt <= pad_cnt + 1'b1;
        end
    end

    // next state, timer and shifter control
    always_comb begin
        state_n  = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_byte  = 8'h00;
        unique case (state)
            ST_IDLE: begin
                if (start_i && !partial_i) begin
                    state_n  = ST_RST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RST_CYC);
                end
            end
            ST_RST_HOLD:  if (tmr_zero) state_n = ST_RST_CHECK;
            ST_RST_CHECK: begin
                if (done_s) begin
                    state_n = ST_IDLE;
                end else begin
                    state_n  = ST_HOUSEKEEP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HK_CYC);
                end
            end
            ST_HOUSEKEEP: if (tmr_zero) state_n = ST_CS_GAP;
            ST_CS_GAP:    state_n = ST_STREAM;
            ST_STREAM: begin
                if (s_valid_i) begin
                    sh_load = 1'b1;
                    sh_byte = s_data_i;
                    state_n = ST_SHIFT;
                end
            end
            ST_SHIFT:      if (sh_fin) state_n = last_q ? ST_LOAD_CHECK : ST_STREAM;
            ST_LOAD_CHECK: state_n = done_s ? ST_PAD : ST_IDLE;
            ST_PAD: begin
                sh_load = 1'b1;
                state_n = ST_PAD_SHIFT;
            end
            ST_PAD_SHIFT: begin
                if (sh_fin) state_n = (pad_cnt == PW'(PAD_BYTES - 1)) ? ST_FINISH : ST_PAD;
            end
            ST_FINISH: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        tgt_rst_n_o = (state != ST_RST_HOLD);
        spi_cs_n_o  = !(state inside {ST_RST_HOLD, ST_RST_CHECK, ST_HOUSEKEEP,
                                      ST_STREAM, ST_SHIFT, ST_LOAD_CHECK,
                                      ST_PAD, ST_PAD_SHIFT});
        busy_o      = (state != ST_IDLE);
        done_ok_o   = (state == ST_FINISH);
        s_ready_o   = (state == ST_STREAM);
        operating_o = (state == ST_IDLE) && ok_q && done_s;
        err_o       = err_q;
    end

    loader_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .value (tmr_val),
        .zero  (tmr_zero)
    );

    loader_shifter #(.HALF_DIV(HALF_DIV)) u_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (sh_load),
        .byte_i (sh_byte),
        .sclk_o (spi_sclk_o),
        .mosi_o (spi_mosi_o),
        .fin_o  (sh_fin)
    );

    assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n_o |-> !spi_sclk_o);

    assert_rst_with_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_rst_n_o |-> !spi_cs_n_o);

    assert_ready_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> (tgt_rst_n_o && !spi_cs_n_o && !spi_sclk_o));

    assert_reset_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RST_CHECK && done_s) |=> (err_o == ERR_RESET && !busy_o));

    assert_load_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD_CHECK && !done_s) |=> (err_o == ERR_LOAD && spi_cs_n_o));

    assert_ok_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok_o |=> !done_ok_o);

    assert_partial_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && partial_i && !busy_o) |=> (tgt_rst_n_o && !busy_o));

    assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !busy_o) |=> $stable(err_o));

endmodule

// File: tb/fpga_spi_loader_bench.sv
module fpga_spi_loader_bench;

    localparam longint unsigned CLK_HZ = 125_000_000;
    localparam int RESET_US  = 1;
    localparam int HK_US     = 8;
    localparam int HALF_DIV  = 3;
    localparam int PAD_BYTES = 7;
    localparam int RST_MIN   = 125;
    localparam int HK_MIN    = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       partial_i = 1'b0;
    logic [7:0] s_data_i = 8'h00;
    logic       s_valid_i = 1'b0;
    logic       s_last_i = 1'b0;
    logic       done_in_i = 1'b0;
    logic       s_ready_o, tgt_rst_n_o, spi_cs_n_o, spi_sclk_o, spi_mosi_o;
    logic       busy_o, done_ok_o, operating_o;
    logic [1:0] err_o;

    always #4 clk = ~clk;

    fpga_spi_loader #(
        .CLK_HZ(CLK_HZ), .RESET_US(RESET_US), .HK_US(HK_US),
        .HALF_DIV(HALF_DIV), .PAD_BYTES(PAD_BYTES)
    ) u_fpga_spi_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .partial_i(partial_i),
        .s_data_i(s_data_i), .s_valid_i(s_valid_i), .s_last_i(s_last_i),
        .s_ready_o(s_ready_o), .done_in_i(done_in_i), .tgt_rst_n_o(tgt_rst_n_o),
        .spi_cs_n_o(spi_cs_n_o), .spi_sclk_o(spi_sclk_o), .spi_mosi_o(spi_mosi_o),
        .busy_o(busy_o), .done_ok_o(done_ok_o), .err_o(err_o),
        .operating_o(operating_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];

    // monitor statistics, cleared per run
    int rst_low, rst_falls, hk_win, cs_rises, sclk_rises, early_edges;
    int idle_bad, ok_pulses, period_seen, cyc, last_rise, bitcnt;
    logic [7:0] cur;
    logic prev_sclk = 1'b0, prev_cs = 1'b1, prev_rst = 1'b1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        rst_low = 0; rst_falls = 0; hk_win = 0; cs_rises = 0; sclk_rises = 0;
        early_edges = 0; idle_bad = 0; ok_pulses = 0; period_seen = -1;
        last_rise = -100; bitcnt = 0; cur = 8'h00;
        exp_q.delete();
    endtask

    // monitor: reassembles bytes at SCLK rises and pops the scoreboard
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!tgt_rst_n_o) rst_low++;
            if (prev_rst && !tgt_rst_n_o) rst_falls++;
            if (!spi_cs_n_o && tgt_rst_n_o && rst_falls > 0 && cs_rises == 0) hk_win++;
            if (spi_cs_n_o && !prev_cs) begin
                cs_rises++;
                bitcnt = 0;
            end
            if (spi_cs_n_o && spi_sclk_o) idle_bad++;
            if (done_ok_o) ok_pulses++;
            if (spi_sclk_o && !prev_sclk) begin
                sclk_rises++;
                if (cs_rises == 0) early_edges++;
                if (bitcnt != 0 && period_seen < 0) period_seen = cyc - last_rise;
                last_rise = cyc;
                cur = {cur[6:0], spi_mosi_o};
                bitcnt++;
                if (bitcnt == 8) begin
                    bitcnt = 0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R6 unexpected byte", cur, -1);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(cur == e, "R6/R8 byte on MOSI", cur, e);
                    end
                end
            end
        end
        prev_sclk = spi_sclk_o;
        prev_cs   = spi_cs_n_o;
        prev_rst  = tgt_rst_n_o;
    end

    task automatic pulse_start(input bit part);
        @(negedge clk);
        start_i = 1'b1;
        partial_i = part;
        @(negedge clk);
        start_i = 1'b0;
        partial_i = 1'b0;
    endtask

    // driver: hands a byte over and pushes its expectation
    task automatic send_byte(input logic [7:0] b, input bit last);
        @(negedge clk);
        s_data_i = b;
        s_last_i = last;
        s_valid_i = 1'b1;
        while (!s_ready_o) @(negedge clk);
        exp_q.push_back(b);
        @(negedge clk);
        s_valid_i = 1'b0;
        s_last_i = 1'b0;
    endtask

    task automatic push_pad();
        for (int i = 0; i < PAD_BYTES; i++) exp_q.push_back(8'h00);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy_o && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(!busy_o, "R8 sequence returns to idle", busy_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_stats();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(tgt_rst_n_o && spi_cs_n_o && !spi_sclk_o, "R1 pins idle",
            {tgt_rst_n_o, spi_cs_n_o, spi_sclk_o}, 3'b110);
        chk(!busy_o && !done_ok_o && !s_ready_o, "R1 status idle",
            {busy_o, done_ok_o, s_ready_o}, 0);
        chk(err_o == 2'd0, "R1 err clear", err_o, 0);

        // successful load with a stall between bytes and a mid-run start
        clear_stats();
        done_in_i = 1'b0;
        pulse_start(1'b0);
        repeat (300) @(negedge clk);
        pulse_start(1'b0);  // R12: must be ignored
        send_byte(8'hA5, 1'b0);
        repeat (70) @(negedge clk);
        send_byte(8'h3C, 1'b0);
        send_byte(8'h81, 1'b1);
        done_in_i = 1'b1;
        push_pad();
        wait_idle();
        chk(err_o == 2'd0, "R8 no error after good load", err_o, 0);
        chk(ok_pulses == 1, "R8 single done_ok pulse", ok_pulses, 1);
        chk(exp_q.size() == 0, "R8 all bytes and padding seen", exp_q.size(), 0);
        chk(sclk_rises == 8 * (3 + PAD_BYTES), "R8 total clock count", sclk_rises, 80);
        chk(cs_rises == 2, "R8 chip select held through padding", cs_rises, 2);
        chk(rst_falls == 1, "R12 one target reset per run", rst_falls, 1);
        chk(rst_low >= RST_MIN, "R2 reset hold length", rst_low, RST_MIN);
        chk(hk_win >= HK_MIN, "R4 housekeeping length", hk_win, HK_MIN);
        chk(early_edges == 0, "R4 no clock before chip select gap", early_edges, 0);
        chk(period_seen == 2 * HALF_DIV, "R5 SCLK period", period_seen, 2 * HALF_DIV);
        chk(idle_bad == 0, "R5 SCLK idle while deselected", idle_bad, 0);
        repeat (4) @(negedge clk);
        chk(operating_o == 1'b1, "R11 operating mirrors done high", operating_o, 1);
        done_in_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(operating_o == 1'b0, "R11 operating follows done low", operating_o, 0);
        done_in_i = 1'b1;

        // reset failure: done stays high across the target reset
        clear_stats();
        repeat (4) @(negedge clk);
        pulse_start(1'b0);
        wait_idle();
        chk(err_o == 2'd1, "R3 reset failure code", err_o, 1);
        chk(sclk_rises == 0, "R3 no clocks after reset failure", sclk_rises, 0);
        chk(tgt_rst_n_o && spi_cs_n_o, "R3 pins released", {tgt_rst_n_o, spi_cs_n_o}, 3);
        chk(operating_o == 1'b0, "R11 no operating after failure", operating_o, 0);
        repeat (50) @(negedge clk);
        chk(err_o == 2'd1, "R10 error held while idle", err_o, 1);

        // load failure: done never rises
        clear_stats();
        done_in_i = 1'b0;
        repeat (4) @(negedge clk);
        pulse_start(1'b0);
        chk(err_o == 2'd0, "R10 start clears error", err_o, 0);
        send_byte(8'h5A, 1'b0);
        send_byte(8'hF0, 1'b1);
        wait_idle();
        chk(err_o == 2'd2, "R7 load failure code", err_o, 2);
        chk(sclk_rises == 16, "R7 no padding after load failure", sclk_rises, 16);
        chk(exp_q.size() == 0, "R6 image bytes MSB first", exp_q.size(), 0);
        chk(ok_pulses == 0, "R7 no done_ok", ok_pulses, 0);

        // partial reconfiguration request
        clear_stats();
        pulse_start(1'b1);
        chk(err_o == 2'd3, "R9 unsupported code", err_o, 3);
        chk(!busy_o, "R9 stays idle", busy_o, 0);
        repeat (20) @(negedge clk);
        chk(rst_falls == 0, "R9 target reset untouched", rst_falls, 0);
        chk(err_o == 2'd3, "R10 unsupported code held", err_o, 3);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule